// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the processor-facing register set of a 16550-compatible serial port. The host reaches eight byte-wide locations through a 3-bit offset, a write strobe, a read strobe and an 8-bit write bus. Read data is returned combinationally in the same cycle as the read strobe. Side effects of a read, such as popping a character or clearing a flag, take effect at the clock edge that ends that cycle. One level-sensitive interrupt line tells the host that some enabled condition needs service.

There is no serial shifter, so the transmitter always reports itself empty and ready. Received characters come from an external one-cycle push port, or, when loopback is selected, from host writes to the data location. They are held in a small receive queue. The queue holds a parameterised number of entries when the FIFO mode is enabled and a single entry when it is disabled. The interrupt identification is prioritised, and reading it has a side effect on the transmit-ready flag. The modem-status location reflects the modem-control outputs while in loopback. Outside loopback it reports carrier-detect and data-set-ready as asserted.

Top module: `uart_regbank`

## Requirements
- R1: After reset the bank reads: divisor low 0x01, divisor high 0x00, interrupt enable 0x00, line control 0x00, modem control 0x00, identification 0x01, line status 0x60 and modem status 0xA0. The interrupt line is low.
- R2: While line-control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. The data and interrupt-enable locations are then untouched.
- R3: Interrupt enable (offset 1) keeps only bits 3:0, and modem control (offset 4) keeps only bits 4:0. Writes to line status (offset 5) and modem status (offset 6) change nothing.
- R4: A write to offset 2 with bit 0 clear stores zero in the FIFO control. With bit 0 set it keeps only bits 7:6, 3 and 0. Identification reads carry bits 7:6 = 11 while FIFO control bit 0 is set, and 00 otherwise.
- R5: The receive queue is emptied whenever FIFO control bit 0 changes value, and when bit 0 and bit 1 are both written as 1. It accepts DEPTH characters when bit 0 is set and one character when it is clear.
- R6: A line-status read returns 0x60 | overrun<<1 | (queue not empty), and then clears the overrun bit.
- R7: With modem-control bit 4 (loopback) set, a data write pushes the byte into the receive queue, and the external push port is ignored. A push into a full queue drops the byte and sets overrun.
- R8: Identification bits 3:0 report the highest-priority enabled cause, in this order: overrun with IER bit 2 → 0x6; queue not empty with IER bit 0 → 0xC; transmit-ready pending with IER bit 1 → 0x2; any modem delta with IER bit 3 → 0x0; otherwise 0x1.
- R9: The transmit-ready pending flag is set by every data write (DLAB clear) and by IER bit 1 going from 0 to 1. It is cleared by an identification read that returns code 0x2.
- R10: A modem-control write updates modem status. In loopback, bits 4,5,6,7 take MCR bits 1,0,2,3; outside loopback the status is 0xA0. Delta bits 0, 1 and 3 latch a change of bits 4, 5 and 7, and bit 2 latches a 1→0 change of bit 6. A modem-status read returns the value and then clears bits 3:0.
- R11: The interrupt line is high exactly when the identification code is not 0x1.
- R12: Data reads with DLAB clear return received characters in arrival order and remove them. A data read of an empty queue returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access; wins over rd_en |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| rx_valid | input | 1 | External receive push strobe |
| rx_data | input | 8 | External receive character |
| irq | output | 1 | Level interrupt request |

## Verification
Most internal state is visible at the ports only through a read that also changes it. A stuck transmit-ready flag or overrun bit therefore shows up on the second of two back-to-back reads of the identification or line-status location, one cycle later. A queue pointer or count error first appears as a wrong line-status bit 0 or a misordered data byte when the queue is drained. It is exposed most sharply at the one-entry and full-depth limits, where an overflow must set overrun exactly once. A wrong modem delta appears on the next modem-status read and as a spurious code 0x0 on the interrupt line.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_IER  = 3'd1,
        OFS_IID  = 3'd2,
        OFS_LCR  = 3'd3,
        OFS_MCR  = 3'd4,
        OFS_LSR  = 3'd5,
        OFS_MSR  = 3'd6,
        OFS_SCR  = 3'd7
    } ofs_e;

    localparam logic [3:0] IID_NONE  = 4'h1;
    localparam logic [3:0] IID_LINE  = 4'h6;
    localparam logic [3:0] IID_TOUT  = 4'hC;
    localparam logic [3:0] IID_TXRDY = 4'h2;
    localparam logic [3:0] IID_MODEM = 4'h0;

    // enable bits
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    // modem control bits
    localparam int MC_DTR  = 0;
    localparam int MC_RTS  = 1;
    localparam int MC_OUT1 = 2;
    localparam int MC_OUT2 = 3;
    localparam int MC_LOOP = 4;

    // FIFO control
    localparam logic [7:0] FC_KEEP = 8'hC9;
    localparam int FC_EN    = 0;
    localparam int FC_RXCLR = 1;

    localparam logic [7:0] LS_TX_IDLE = 8'h60;

    typedef struct packed {
        logic [7:0] ier;
        logic [7:0] lcr;
        logic [7:0] mcr;
        logic [7:0] fcr;
        logic [7:0] scr;
        logic [7:0] dll;
        logic [7:0] dlh;
        logic [7:0] msr;
        logic       ovr;
        logic       txp;
    } bank_t;

endpackage

// File: rtl/uart_rxq.sv
module uart_rxq #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       single,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop,
    output logic [7:0] head,
    output logic       empty,
    output logic       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [7:0] mem_q [DEPTH];
    logic [CW-1:0] limit;
    logic do_push, do_pop;

    assign limit = single ? CW'(1) : CAP;
    assign full  = (s_q.cnt >= limit);
    assign empty = (s_q.cnt == '0);
    assign head  = mem_q[s_q.rp];

    always_comb begin
        s_d     = s_q;
        do_push = push && !full && !clear;
        do_pop  = pop && !empty && !clear;
        if (clear) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wp = (s_q.wp == LAST) ? '0 : s_q.wp + 1'b1;
            if (do_pop)  s_d.rp = (s_q.rp == LAST) ? '0 : s_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wp] <= push_data;
    end

    // R5: occupancy never exceeds the active capacity
    p_cnt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= limit);
    // R5: a clear leaves the queue empty
    p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);
endmodule

// File: rtl/uart_modem_map.sv
module uart_modem_map
    import uart_regbank_pkg::*;
(
    input  logic [7:0] mcr,
    output logic [7:0] status
);
    always_comb begin
        if (mcr[MC_LOOP]) begin
            status = {mcr[MC_OUT2], mcr[MC_OUT1], mcr[MC_DTR], mcr[MC_RTS], 4'b0000};
        end else begin
            status = 8'hA0;
        end
    end
endmodule

// File: rtl/uart_int_prio.sv
module uart_int_prio
    import uart_regbank_pkg::*;
(
    input  logic [3:0] ier,
    input  logic       ovr,
    input  logic       rx_avail,
    input  logic       txp,
    input  logic [3:0] msr_delta,
    output logic [3:0] code,
    output logic       irq
);
    always_comb begin
        if (ovr && ier[EN_LINE])                    code = IID_LINE;
        else if (rx_avail && ier[EN_RX])            code = IID_TOUT;
        else if (txp && ier[EN_TX])                 code = IID_TXRDY;
        else if ((|msr_delta) && ier[EN_MODEM])     code = IID_MODEM;
        else                                        code = IID_NONE;
    end

    assign irq = (code != IID_NONE);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int REF_CLK_HZ = 1843200,
    parameter int BAUD       = 115200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       irq
);
    localparam logic [15:0] RST_DIV = 16'(REF_CLK_HZ / BAUD / 16);

    bank_t r_d, r_q;

    logic       rd_act, dl_sel, loop_q;
    logic       q_clear, q_push, q_pop, q_empty, q_full, set_ovr;
    logic [7:0] q_pdata, q_head;
    logic [7:0] mcr_new, ms_new;
    logic [3:0] iid_code;

    assign rd_act = rd_en && !wr_en;
    assign dl_sel = r_q.lcr[7] && (addr == OFS_DATA || addr == OFS_IER);
    assign loop_q = r_q.mcr[MC_LOOP];
    assign mcr_new = wdata & 8'h1F;

    uart_modem_map u_map (
        .mcr    (mcr_new),
        .status (ms_new)
    );

    uart_int_prio u_prio (
        .ier       (r_q.ier[3:0]),
        .ovr       (r_q.ovr),
        .rx_avail  (!q_empty),
        .txp       (r_q.txp),
        .msr_delta (r_q.msr[3:0]),
        .code      (iid_code),
        .irq       (irq)
    );

    uart_rxq #(.DEPTH(FIFO_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (q_clear),
        .single    (!r_q.fcr[FC_EN]),
        .push      (q_push),
        .push_data (q_pdata),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    always_comb begin
        r_d     = r_q;
        q_clear = 1'b0;
        q_push  = rx_valid && !loop_q;
        q_pdata = rx_data;
        q_pop   = 1'b0;

        if (wr_en) begin
            if (dl_sel) begin
                if (addr == OFS_DATA) r_d.dll = wdata;
                else                  r_d.dlh = wdata;
            end else begin
                case (ofs_e'(addr))
                    OFS_DATA: begin
                        r_d.txp = 1'b1;
                        if (loop_q) begin
                            q_push  = 1'b1;
                            q_pdata = wdata;
                        end
                    end
                    OFS_IER: begin
                        if (!r_q.ier[EN_TX] && wdata[EN_TX]) r_d.txp = 1'b1;
                        r_d.ier = {4'b0000, wdata[3:0]};
                    end
                    OFS_IID: begin
                        if (r_q.fcr[FC_EN] != wdata[FC_EN]) q_clear = 1'b1;
                        if (wdata[FC_EN] && wdata[FC_RXCLR]) q_clear = 1'b1;
                        r_d.fcr = wdata[FC_EN] ? (wdata & FC_KEEP) : 8'h00;
                    end
                    OFS_LCR: r_d.lcr = wdata;
                    OFS_MCR: begin
                        r_d.mcr = mcr_new;
                        r_d.msr[7:4] = ms_new[7:4];
                        r_d.msr[0] = r_q.msr[0] | (r_q.msr[4] ^ ms_new[4]);
                        r_d.msr[1] = r_q.msr[1] | (r_q.msr[5] ^ ms_new[5]);
                        r_d.msr[2] = r_q.msr[2] | (r_q.msr[6] & ~ms_new[6]);
                        r_d.msr[3] = r_q.msr[3] | (r_q.msr[7] ^ ms_new[7]);
                    end
                    OFS_SCR: r_d.scr = wdata;
                    default: ;
                endcase
            end
        end else if (rd_act && !dl_sel) begin
            case (ofs_e'(addr))
                OFS_DATA: q_pop = 1'b1;
                OFS_IID:  if (iid_code == IID_TXRDY) r_d.txp = 1'b0;
                OFS_LSR:  r_d.ovr = 1'b0;
                OFS_MSR:  r_d.msr[3:0] = 4'b0000;
                default: ;
            endcase
        end

        set_ovr = q_push && q_full && !q_clear;
        if (set_ovr) r_d.ovr = 1'b1;
    end

    always_comb begin
        rdata = 8'h00;
        if (dl_sel) begin
            rdata = (addr == OFS_DATA) ? r_q.dll : r_q.dlh;
        end else begin
            case (ofs_e'(addr))
                OFS_DATA: rdata = q_empty ? 8'h00 : q_head;
                OFS_IER:  rdata = r_q.ier;
                OFS_IID:  rdata = {{2{r_q.fcr[FC_EN]}}, 2'b00, iid_code};
                OFS_LCR:  rdata = r_q.lcr;
                OFS_MCR:  rdata = r_q.mcr;
                OFS_LSR:  rdata = LS_TX_IDLE | {6'b0, r_q.ovr, !q_empty};
                OFS_MSR:  rdata = r_q.msr;
                OFS_SCR:  rdata = r_q.scr;
                default:  rdata = 8'hFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.dll <= RST_DIV[7:0];
            r_q.dlh <= RST_DIV[15:8];
            r_q.msr <= 8'hA0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: divisor low byte captures the write while DLAB is set
    p_dll_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && r_q.lcr[7] && addr == OFS_DATA) |=> (r_q.dll == $past(wdata)));
    // R9: a plain data write leaves transmit-ready pending
    p_txp_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !r_q.lcr[7] && addr == OFS_DATA) |=> r_q.txp);
    // R6: a line-status read clears overrun unless a new overflow lands
    p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && addr == OFS_LSR && !set_ovr) |=> !r_q.ovr);
    // R4: disabled FIFO control holds all zero
    p_fcr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.fcr[FC_EN] |-> (r_q.fcr == 8'h00));
    // R8: no enables, no interrupt
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ier[3:0] == 4'h0) |-> !irq);
    // R10: modem-status read clears the delta nibble
    p_msr_rdclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !r_q.lcr[7] && addr == OFS_MSR) |=> (r_q.msr[3:0] == 4'h0));
endmodule

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    uart_regbank u_uart_regbank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .irq(irq)
    );

    // monitor: compares each read against the queued expectation
    always @(negedge clk) begin
        if (rd_en && !wr_en && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic rx(input logic [7:0] d);
        rx_data = d; rx_valid = 1'b1;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset values
        chk_irq(1'b0, "R1 irq");
        rd(3'd1, 8'h00, "R1 ier");
        rd(3'd2, 8'h01, "R1 iid");
        rd(3'd5, 8'h60, "R1 lsr");
        rd(3'd6, 8'hA0, "R1 msr");
        rd(3'd4, 8'h00, "R1 mcr");
        rd(3'd3, 8'h00, "R1 lcr");

        // R2 divisor latch access
        wr(3'd3, 8'h80);
        rd(3'd0, 8'h01, "R1 dll");
        rd(3'd1, 8'h00, "R1 dlh");
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd(3'd0, 8'h34, "R2 dll");
        rd(3'd1, 8'h12, "R2 dlh");
        wr(3'd3, 8'h03);
        rd(3'd1, 8'h00, "R2 ier untouched");
        rd(3'd2, 8'h01, "R2 no txp from dl write");
        rd(3'd3, 8'h03, "R2 lcr");
        wr(3'd7, 8'h5A);
        rd(3'd7, 8'h5A, "R3 scratch");

        // R3 / R9 enable mask and edge
        wr(3'd1, 8'hFF);
        rd(3'd1, 8'h0F, "R3 ier mask");
        chk_irq(1'b1, "R11 irq on txp");
        rd(3'd2, 8'h02, "R9 iid tx");
        rd(3'd2, 8'h01, "R9 cleared by read");
        chk_irq(1'b0, "R11 irq idle");
        wr(3'd1, 8'h0F);
        rd(3'd2, 8'h01, "R9 no edge");

        // R10 modem status in loopback
        wr(3'd4, 8'hFF);
        rd(3'd4, 8'h1F, "R3 mcr mask");
        chk_irq(1'b1, "R11 irq modem");
        rd(3'd2, 8'h00, "R8 modem code");
        rd(3'd6, 8'hF1, "R10 msr loop");
        rd(3'd6, 8'hF0, "R10 delta clear");
        rd(3'd2, 8'h01, "R10 iid after clear");
        wr(3'd4, 8'h10);
        rd(3'd6, 8'h0F, "R10 all deltas");
        rd(3'd6, 8'h00, "R10 loop quiet");

        // R3 read-only locations
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'hFF);
        rd(3'd5, 8'h60, "R3 lsr write ignored");
        rd(3'd6, 8'h00, "R3 msr write ignored");

        // R7 / R8 single-entry queue in loopback
        wr(3'd0, 8'h11);
        rd(3'd2, 8'h0C, "R8 timeout over tx");
        wr(3'd0, 8'h22);
        rd(3'd2, 8'h06, "R8 line status top");
        rd(3'd5, 8'h63, "R7 overrun set");
        rd(3'd5, 8'h61, "R6 overrun cleared");
        rd(3'd0, 8'h11, "R12 first byte kept");
        rd(3'd2, 8'h02, "R8 tx after rx");
        rd(3'd2, 8'h01, "R9 tx cleared");
        rd(3'd0, 8'h00, "R12 empty read");

        // R4 / R5 FIFO mode
        wr(3'd2, 8'hC9);
        rd(3'd2, 8'hC1, "R4 iid high bits");
        wr(3'd0, 8'hA1);
        wr(3'd0, 8'hA2);
        wr(3'd0, 8'hA3);
        rd(3'd5, 8'h61, "R5 deep no overrun");
        wr(3'd2, 8'h03);
        rd(3'd5, 8'h60, "R5 receive reset");
        rd(3'd2, 8'hC2, "R4 tx code in fifo mode");
        rd(3'd2, 8'hC1, "R4 idle fifo mode");
        for (int i = 0; i < 16; i++) wr(3'd0, 8'h40 + 8'(i));
        wr(3'd0, 8'h99);
        rd(3'd2, 8'hC6, "R7 overflow at depth");
        rd(3'd5, 8'h63, "R7 full depth overrun");
        for (int i = 0; i < 16; i++) rd(3'd0, 8'h40 + 8'(i), "R12 order");
        rd(3'd5, 8'h60, "R12 drained");
        rd(3'd2, 8'hC2, "R9 tx after drain");
        rd(3'd2, 8'hC1, "R9 cleared");
        wr(3'd0, 8'h5A);
        wr(3'd0, 8'h5B);
        wr(3'd2, 8'hFE);
        rd(3'd5, 8'h60, "R5 disable empties");
        rd(3'd2, 8'h02, "R4 bits clear when off");
        rd(3'd2, 8'h01, "R4 idle off");

        // R7 external port
        wr(3'd4, 8'h00);
        rd(3'd6, 8'hAA, "R10 leave loopback");
        rx(8'h77);
        rd(3'd5, 8'h61, "R7 external push");
        rd(3'd2, 8'h0C, "R8 rx code");
        rd(3'd0, 8'h77, "R12 external byte");
        rd(3'd2, 8'h01, "R8 idle");
        wr(3'd4, 8'h10);
        rd(3'd6, 8'h0A, "R10 enter loopback");
        rx(8'h55);
        rd(3'd5, 8'h60, "R7 external ignored in loop");

        // R8 masking and R9 enable edge
        wr(3'd4, 8'h00);
        rd(3'd6, 8'hAA, "R10 deltas again");
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h33);
        chk_irq(1'b0, "R8 masked irq");
        rd(3'd2, 8'h01, "R8 masked code");
        wr(3'd1, 8'h02);
        chk_irq(1'b1, "R11 tx irq");
        rd(3'd2, 8'h02, "R9 enable edge");
        chk_irq(1'b0, "R11 irq dropped");

        @(posedge clk); #1;
        finish_run();
    end
endmodule